// File: doc/BRIEF.md
# Gapped Byte-Enable Access Splitter

This block sits between a 32-bit little-endian data phase and a 64-bit big-endian internal bus. It takes one data phase, made of four active-low byte enables, a half-select bit that chooses the upper or lower word of the doubleword, and 32 bits of data. It turns that phase into internal-bus requests. Each request covers one contiguous run of enabled bytes, so each one carries a start byte address, a size of 1 to 4 bytes, lane enables and data placed in big-endian lane order.

A contiguous enable pattern gives a single request. A pattern with a gap gives one request per run, lowest address first. Each request is held until the bus acknowledges it, and the next one appears only after that acknowledge. A one-cycle completion pulse follows the final acknowledge. A new data phase is taken only while no request is outstanding.

Top module: `be_split_top`

## Requirements
- R1: After reset, `req_valid` and `done` are 0 and `in_ready` is 1.
- R2: A phase is accepted on a clock edge only when `in_valid` and `in_ready` are both 1. `in_ready` is 0 while a request is outstanding, and a phase presented during that time produces no request and changes no request field.
- R3: `in_be_n[k]` low enables input byte k, which is `in_data[8k+7:8k]` at byte offset k. A contiguous run of enabled bytes produces exactly one request. Its `req_size` equals the number of enabled bytes and its address is the offset of the lowest one.
- R4: A pattern with a gap produces one request per run, in ascending address order, and each following request appears only after the previous one is acknowledged. The cases are:
  - bytes {0,2}: 1 byte at offset 0, then 1 byte at offset 2.
  - bytes {0,3}: 1 byte at offset 0, then 1 byte at offset 3.
  - bytes {1,3}: 1 byte at offset 1, then 1 byte at offset 3.
  - bytes {0,2,3}: 1 byte at offset 0, then 2 bytes at offset 2.
  - bytes {0,1,3}: 2 bytes at offset 0, then 1 byte at offset 3.
- R5: With `in_half` = 1, every request address is 4 higher than the address for the same pattern with `in_half` = 0.
- R6: For a request, the byte at internal address a sits in `req_data[63-8a -: 8]` and sets `req_lane_en[a]`. All other lanes and enables are 0.
- R7: While `req_valid` is 1 and `req_ack` is 0, all request fields hold their values on the next cycle.
- R8: `done` is 1 for the single cycle after the clock edge that takes the final acknowledge. A phase with no byte enabled produces no request, and `done` rises the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data phase present |
| in_ready | output | 1 | Block idle, phase can be taken |
| in_be_n | input | 4 | Active-low byte enables |
| in_half | input | 1 | Upper word of the doubleword |
| in_data | input | 32 | Little-endian phase data |
| req_valid | output | 1 | Internal request outstanding |
| req_ack | input | 1 | Internal bus takes the request |
| req_addr | output | 3 | Request start byte address |
| req_size | output | 3 | Request length in bytes (1 to 4) |
| req_data | output | 64 | Big-endian lane data |
| req_lane_en | output | 8 | Active-high lane enables, bit a = address a |
| done | output | 1 | Final access acknowledged |

## Verification
The hardest case to reach is a second request whose acknowledge is delayed while a new data phase is pressing at the input. In that case a wrongly accepted phase would overwrite the remaining bytes or the held data. The bench sweeps every enable pattern with both half-select values. It repeats the sweep with acknowledge delays of zero and several cycles, and during the delayed waits it drives a conflicting phase. It then checks that the request sequence and the quiet cycle after completion are unchanged.

// File: rtl/be_split_pkg.sv
package be_split_pkg;
  localparam int unsigned LANE_BITS = 8;

  function automatic int unsigned lane_lsb(input int unsigned addr, input int unsigned bus_bytes);
    return (bus_bytes - 1 - addr) * LANE_BITS;
  endfunction
endpackage

// File: rtl/be_run_finder.sv
module be_run_finder #(
  parameter int unsigned N = 4,
  localparam int unsigned OFF_W = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned SIZE_W = $clog2(N) + 1
) (
  input  logic [N-1:0]      mask,
  output logic              found,
  output logic [OFF_W-1:0]  start,
  output logic [SIZE_W-1:0] len,
  output logic [N-1:0]      rest
);
  logic seen;
  logic inrun;

  always_comb begin
    found = |mask;
    start = '0;
    len   = '0;
    rest  = mask;
    seen  = 1'b0;
    inrun = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (mask[i]) begin
        if (!seen) begin
          seen  = 1'b1;
          inrun = 1'b1;
          start = OFF_W'(i);
        end
        if (inrun) begin
          len     = len + SIZE_W'(1);
          rest[i] = 1'b0;
        end
      end else if (seen) begin
        inrun = 1'b0;
      end
    end
  end
endmodule

// File: rtl/be_lane_packer.sv
module be_lane_packer
  import be_split_pkg::*;
#(
  parameter int unsigned IN_BYTES  = 4,
  parameter int unsigned BUS_BYTES = 8,
  localparam int unsigned OFF_W  = $clog2(IN_BYTES),
  localparam int unsigned SIZE_W = $clog2(IN_BYTES) + 1,
  localparam int unsigned ADDR_W = $clog2(BUS_BYTES),
  localparam int unsigned HALF_W = ADDR_W - OFF_W,
  localparam int unsigned HALVES = BUS_BYTES / IN_BYTES
) (
  input  logic [HALF_W-1:0]         half,
  input  logic [OFF_W-1:0]          start,
  input  logic [SIZE_W-1:0]         len,
  input  logic [IN_BYTES*8-1:0]     data,
  output logic [ADDR_W-1:0]         addr,
  output logic [BUS_BYTES*8-1:0]    lanes,
  output logic [BUS_BYTES-1:0]      lane_en
);
  logic [IN_BYTES-1:0] in_run;

  always_comb begin
    for (int k = 0; k < int'(IN_BYTES); k++) begin
      in_run[k] = (k >= int'(start)) && (k < int'(start) + int'(len));
    end
  end

  always_comb begin
    addr    = {half, start};
    lanes   = '0;
    lane_en = '0;
    for (int h = 0; h < int'(HALVES); h++) begin
      for (int k = 0; k < int'(IN_BYTES); k++) begin
        if (int'(half) == h && in_run[k]) begin
          lanes[lane_lsb(h*IN_BYTES + k, BUS_BYTES) +: LANE_BITS] = data[k*LANE_BITS +: LANE_BITS];
          lane_en[h*IN_BYTES + k] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/be_split_top.sv
module be_split_top #(
  parameter int unsigned IN_BYTES  = 4,
  parameter int unsigned BUS_BYTES = 8,
  localparam int unsigned OFF_W  = $clog2(IN_BYTES),
  localparam int unsigned SIZE_W = $clog2(IN_BYTES) + 1,
  localparam int unsigned ADDR_W = $clog2(BUS_BYTES),
  localparam int unsigned HALF_W = ADDR_W - OFF_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [IN_BYTES-1:0]    in_be_n,
  input  logic [HALF_W-1:0]      in_half,
  input  logic [IN_BYTES*8-1:0]  in_data,
  output logic                   req_valid,
  input  logic                   req_ack,
  output logic [ADDR_W-1:0]      req_addr,
  output logic [SIZE_W-1:0]      req_size,
  output logic [BUS_BYTES*8-1:0] req_data,
  output logic [BUS_BYTES-1:0]   req_lane_en,
  output logic                   done
);
  logic [IN_BYTES-1:0]    rem_q;
  logic [IN_BYTES*8-1:0]  data_q;
  logic [HALF_W-1:0]      half_q;

  logic [IN_BYTES-1:0]    src_mask;
  logic [IN_BYTES*8-1:0]  src_data;
  logic [HALF_W-1:0]      src_half;

  logic                   nx_found;
  logic [OFF_W-1:0]       nx_start;
  logic [SIZE_W-1:0]      nx_len;
  logic [IN_BYTES-1:0]    nx_rest;
  logic [ADDR_W-1:0]      nx_addr;
  logic [BUS_BYTES*8-1:0] nx_lanes;
  logic [BUS_BYTES-1:0]   nx_en;

  logic accept;
  logic advance;

  assign in_ready = !req_valid;
  assign accept   = in_valid && in_ready;
  assign advance  = req_valid && req_ack;

  // an outstanding request works on stored state, otherwise on the live input
  assign src_mask = req_valid ? rem_q  : ~in_be_n;
  assign src_data = req_valid ? data_q : in_data;
  assign src_half = req_valid ? half_q : in_half;

  be_run_finder #(.N(IN_BYTES)) u_find (
    .mask  (src_mask),
    .found (nx_found),
    .start (nx_start),
    .len   (nx_len),
    .rest  (nx_rest)
  );

  be_lane_packer #(.IN_BYTES(IN_BYTES), .BUS_BYTES(BUS_BYTES)) u_pack (
    .half    (src_half),
    .start   (nx_start),
    .len     (nx_len),
    .data    (src_data),
    .addr    (nx_addr),
    .lanes   (nx_lanes),
    .lane_en (nx_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid   <= 1'b0;
      req_addr    <= '0;
      req_size    <= '0;
      req_data    <= '0;
      req_lane_en <= '0;
      done        <= 1'b0;
      rem_q       <= '0;
      data_q      <= '0;
      half_q      <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        data_q    <= in_data;
        half_q    <= in_half;
        rem_q     <= nx_rest;
        req_valid <= nx_found;
        done      <= !nx_found;
        if (nx_found) begin
          req_addr    <= nx_addr;
          req_size    <= nx_len;
          req_data    <= nx_lanes;
          req_lane_en <= nx_en;
        end
      end else if (advance) begin
        rem_q <= nx_rest;
        if (nx_found) begin
          req_addr    <= nx_addr;
          req_size    <= nx_len;
          req_data    <= nx_lanes;
          req_lane_en <= nx_en;
        end else begin
          req_valid <= 1'b0;
          done      <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/be_split_chk.sv
module be_split_chk #(
  parameter int unsigned IN_BYTES  = 4,
  parameter int unsigned BUS_BYTES = 8,
  localparam int unsigned OFF_W  = $clog2(IN_BYTES),
  localparam int unsigned SIZE_W = $clog2(IN_BYTES) + 1,
  localparam int unsigned ADDR_W = $clog2(BUS_BYTES),
  localparam int unsigned HALF_W = ADDR_W - OFF_W
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [IN_BYTES-1:0]    in_be_n,
  input logic [HALF_W-1:0]      in_half,
  input logic [IN_BYTES*8-1:0]  in_data,
  input logic                   req_valid,
  input logic                   req_ack,
  input logic [ADDR_W-1:0]      req_addr,
  input logic [SIZE_W-1:0]      req_size,
  input logic [BUS_BYTES*8-1:0] req_data,
  input logic [BUS_BYTES-1:0]   req_lane_en,
  input logic                   done
);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_size)
                              && $stable(req_data) && $stable(req_lane_en));

  p_size_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_size != '0) && ($countones(req_lane_en) == int'(req_size)));

  p_lane_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_lane_en[req_addr]);

  p_order_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ack |=> (req_valid |->
      int'(req_addr) > int'($past(req_addr)) + int'($past(req_size))));

  p_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);

  p_busy_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ack |=> !in_ready);
endmodule

bind be_split_top be_split_chk #(.IN_BYTES(IN_BYTES), .BUS_BYTES(BUS_BYTES)) u_chk (.*);

// File: tb/tb_be_split_top.sv
module tb_be_split_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_be_n;
  logic [0:0]  in_half;
  logic [31:0] in_data;
  logic        req_valid;
  logic        req_ack;
  logic [2:0]  req_addr;
  logic [2:0]  req_size;
  logic [63:0] req_data;
  logic [7:0]  req_lane_en;
  logic        done;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  be_split_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_be_n(in_be_n), .in_half(in_half), .in_data(in_data),
    .req_valid(req_valid), .req_ack(req_ack), .req_addr(req_addr),
    .req_size(req_size), .req_data(req_data), .req_lane_en(req_lane_en),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [3:0] be_n, input bit half, input logic [31:0] data, input int dly);
    int starts[4];
    int lens[4];
    int ng = 0;
    bit inrun = 0;
    logic [3:0] m = ~be_n;
    for (int k = 0; k < 4; k++) begin
      if (m[k]) begin
        if (!inrun) begin starts[ng] = k; lens[ng] = 0; ng++; inrun = 1; end
        lens[ng-1]++;
      end else inrun = 0;
    end

    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready idle", in_ready, 1);
    in_be_n = be_n; in_half = half; in_data = data; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int g = 0; g < ng; g++) begin
      logic [63:0] ed = '0;
      logic [7:0]  ee = '0;
      int base = (half ? 4 : 0) + starts[g];
      for (int j = 0; j < lens[g]; j++) begin
        ed[(7 - (base + j))*8 +: 8] = data[(starts[g] + j)*8 +: 8];
        ee[base + j] = 1'b1;
      end
      chk(req_valid == 1'b1, "R4 request present", req_valid, 1);
      chk(req_addr == 3'(base), "R5 R4 address", req_addr, base);
      chk(req_size == 3'(lens[g]), "R3 size", req_size, lens[g]);
      chk(req_data == ed, "R6 lane data", req_data, ed);
      chk(req_lane_en == ee, "R6 lane enables", req_lane_en, ee);
      for (int w = 0; w < dly; w++) begin
        in_be_n = 4'b0000; in_half = ~half; in_data = ~data; in_valid = 1'b1;
        @(negedge clk);
        chk(req_valid && req_addr == 3'(base) && req_data == ed && req_size == 3'(lens[g]),
            "R7 R2 held while waiting", {req_addr, req_size}, {3'(base), 3'(lens[g])});
        chk(in_ready == 1'b0, "R2 busy", in_ready, 0);
      end
      in_valid = 1'b0;
      req_ack = 1'b1;
      @(negedge clk);
      req_ack = 1'b0;
    end
    chk(req_valid == 1'b0, "R8 idle after last", req_valid, 0);
    chk(done == 1'b1, "R8 done pulse", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    chk(req_valid == 1'b0, "R2 no stray request", req_valid, 0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_be_n = 4'hF; in_half = 1'b0; in_data = '0; req_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R1 req_valid reset", req_valid, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    chk(in_ready == 1'b1, "R1 ready reset", in_ready, 1);
    rst = 1'b0;
    for (int d = 0; d < 3; d++) begin
      for (int h = 0; h < 2; h++) begin
        for (int p = 0; p < 16; p++) begin
          logic [31:0] dat = {8'(8'hD0 + p), 8'(8'hC0 + h*16 + d), 8'(8'hB0 + p), 8'(8'hA0 + d)};
          run_case(4'(p), h[0], dat, d * 2);
        end
      end
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule